// File: doc/BRIEF.md
# Branch Target Address Unit

This unit resolves where control goes after a jump or call in a segmented 16-bit processor. It takes the current code segment and instruction pointer, a three-bit branch kind and every candidate target: a displacement from the instruction, a far pointer held in the instruction, a word from a register, and a word or segment:offset pair already fetched from memory. One clock after a request strobe it presents the resolved segment and pointer. With the pointer it gives a flag that says whether the segment changed, a flag that marks an illegal branch form, and a one-cycle valid pulse.

Intrasegment (near) branches keep the segment. They either add a displacement to the pointer or take a new pointer from a register or from memory. Intersegment (far) branches replace both the segment and the pointer. The new values come either from the instruction itself or from a memory pair. A far indirect branch that names an immediate operand has no meaning, so the unit rejects it with the illegal flag. Fetching the instruction, reading memory and pushing return addresses all happen outside this unit.

Top module: `bta_unit`

## Requirements
- R1: While reset is asserted, and after reset until the first request, valid_o, cs_chg_o and illegal_o are 0, and new_cs_o and new_ip_o are 0.
- R2: valid_o is 1 in the cycle after a cycle with req_i high, and 0 in every other cycle. All outputs are registered and update on that same edge.
- R3: Kind 0 (near, short relative): new_ip_o = cur_ip_i + disp_i[7:0] sign-extended to 16 bits, modulo 2^16. new_cs_o = cur_cs_i.
- R4: Kind 1 (near, long relative): new_ip_o = cur_ip_i + disp_i, modulo 2^16. new_cs_o = cur_cs_i.
- R5: Kind 2 (near, register indirect): new_ip_o = reg_word_i and new_cs_o = cur_cs_i.
- R6: Kind 3 (near, memory indirect): new_ip_o = mem_ip_i and new_cs_o = cur_cs_i.
- R7: Kind 4 (far, pointer in the instruction): new_cs_o = ptr_cs_i and new_ip_o = ptr_ip_i.
- R8: Kind 5 (far, memory indirect): new_cs_o = mem_cs_i and new_ip_o = mem_ip_i.
- R9: cs_chg_o is 1 on a valid result only for kinds 4 and 5. It is 0 for all near and illegal kinds.
- R10: Kind 6 (far indirect naming an immediate) and kind 7 (unassigned) set illegal_o. The result then keeps the current segment and pointer (new_cs_o = cur_cs_i, new_ip_o = cur_ip_i), and cs_chg_o is 0.
- R11: In a cycle with no request, new_cs_o, new_ip_o, cs_chg_o and illegal_o hold the values they had before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; the other inputs are sampled with it |
| kind_i | input | 3 | Branch kind code 0..7 (see R3-R10 entries) |
| cur_cs_i | input | 16 | Current code segment |
| cur_ip_i | input | 16 | Current instruction pointer |
| disp_i | input | 16 | Relative displacement; the short form uses bits 7:0 |
| ptr_cs_i | input | 16 | Segment field of a far pointer in the instruction |
| ptr_ip_i | input | 16 | Offset field of a far pointer in the instruction |
| reg_word_i | input | 16 | Register-supplied near target |
| mem_ip_i | input | 16 | Memory-supplied offset word |
| mem_cs_i | input | 16 | Memory-supplied segment word |
| new_cs_o | output | 16 | Resolved code segment |
| new_ip_o | output | 16 | Resolved instruction pointer |
| cs_chg_o | output | 1 | Segment was replaced by a far branch |
| illegal_o | output | 1 | Branch form is not allowed |
| valid_o | output | 1 | Result pulse, one cycle after req_i |

## Verification
A wrong decode or a wrong adder shows up on new_ip_o or new_cs_o in the first cycle after the request that exercised it. Every result is checked in exactly that cycle. A sign-extension fault only appears with negative short displacements. Wrap-around faults only appear with pointers near the top of the 16-bit range, so directed cases cover both. A flag register that tracks the wrong kind is visible at once on cs_chg_o or illegal_o. A missing hold shows up in the idle cycles between requests, when the outputs must not move.

// File: rtl/bta_pkg.sv
package bta_pkg;
   typedef enum logic [2:0] {
      BK_NEAR_SHORT = 3'd0,
      BK_NEAR_LONG  = 3'd1,
      BK_NEAR_REG   = 3'd2,
      BK_NEAR_MEM   = 3'd3,
      BK_FAR_PTR    = 3'd4,
      BK_FAR_MEM    = 3'd5,
      BK_FAR_IMM    = 3'd6,
      BK_UNUSED     = 3'd7
   } bk_kind_e;

   typedef enum logic [1:0] {
      SRC_REL = 2'd0,
      SRC_REG = 2'd1,
      SRC_MEM = 2'd2,
      SRC_PTR = 2'd3
   } bk_src_e;

   typedef struct packed {
      logic    is_far;
      logic    use_short;
      logic    bad;
      bk_src_e src;
   } bk_ctl_t;
endpackage

// File: rtl/bta_decode.sv
module bta_decode
   import bta_pkg::*;
(
   input  logic [2:0] kind_i,
   output bk_ctl_t    ctl_o
);
   always_comb begin
      ctl_o = '{is_far: 1'b0, use_short: 1'b0, bad: 1'b0, src: SRC_REL};
      case (bk_kind_e'(kind_i))
         BK_NEAR_SHORT: ctl_o.use_short = 1'b1;
         BK_NEAR_LONG:  ctl_o.src = SRC_REL;
         BK_NEAR_REG:   ctl_o.src = SRC_REG;
         BK_NEAR_MEM:   ctl_o.src = SRC_MEM;
         BK_FAR_PTR: begin
            ctl_o.is_far = 1'b1;
            ctl_o.src    = SRC_PTR;
         end
         BK_FAR_MEM: begin
            ctl_o.is_far = 1'b1;
            ctl_o.src    = SRC_MEM;
         end
         default:       ctl_o.bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/bta_disp_ext.sv
module bta_disp_ext #(
   parameter int IP_W     = 16,
   parameter int SHORT_W  = 8,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [IP_W-1:0] disp_i,
   input  logic            use_short_i,
   output logic [IP_W-1:0] disp_o
);
   localparam int PAD_W = IP_W - SHORT_W;

   logic [IP_W-1:0] short_ext;

   generate
      if (SIGN_EXT) begin : g_sext
         assign short_ext = {{PAD_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
      end else begin : g_zext
         assign short_ext = {{PAD_W{1'b0}}, disp_i[SHORT_W-1:0]};
      end
   endgenerate

   assign disp_o = use_short_i ? short_ext : disp_i;
endmodule

// File: rtl/bta_target_sel.sv
module bta_target_sel
   import bta_pkg::*;
#(
   parameter int IP_W  = 16,
   parameter int SEG_W = 16
) (
   input  bk_ctl_t          ctl_i,
   input  logic [SEG_W-1:0] cur_cs_i,
   input  logic [IP_W-1:0]  cur_ip_i,
   input  logic [IP_W-1:0]  disp_i,
   input  logic [SEG_W-1:0] ptr_cs_i,
   input  logic [IP_W-1:0]  ptr_ip_i,
   input  logic [IP_W-1:0]  reg_word_i,
   input  logic [IP_W-1:0]  mem_ip_i,
   input  logic [SEG_W-1:0] mem_cs_i,
   output logic [SEG_W-1:0] cs_o,
   output logic [IP_W-1:0]  ip_o,
   output logic             chg_o
);
   logic [IP_W-1:0] rel_ip;

   assign rel_ip = cur_ip_i + disp_i;

   always_comb begin
      cs_o  = cur_cs_i;
      ip_o  = cur_ip_i;
      chg_o = 1'b0;
      if (!ctl_i.bad) begin
         case (ctl_i.src)
            SRC_REL: ip_o = rel_ip;
            SRC_REG: ip_o = reg_word_i;
            SRC_MEM: begin
               ip_o = mem_ip_i;
               if (ctl_i.is_far) cs_o = mem_cs_i;
            end
            default: begin
               ip_o = ptr_ip_i;
               cs_o = ptr_cs_i;
            end
         endcase
         chg_o = ctl_i.is_far;
      end
   end
endmodule

// File: rtl/bta_unit.sv
module bta_unit
   import bta_pkg::*;
#(
   parameter int IP_W     = 16,
   parameter int SEG_W    = 16,
   parameter int SHORT_W  = 8,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [2:0]       kind_i,
   input  logic [SEG_W-1:0] cur_cs_i,
   input  logic [IP_W-1:0]  cur_ip_i,
   input  logic [IP_W-1:0]  disp_i,
   input  logic [SEG_W-1:0] ptr_cs_i,
   input  logic [IP_W-1:0]  ptr_ip_i,
   input  logic [IP_W-1:0]  reg_word_i,
   input  logic [IP_W-1:0]  mem_ip_i,
   input  logic [SEG_W-1:0] mem_cs_i,
   output logic [SEG_W-1:0] new_cs_o,
   output logic [IP_W-1:0]  new_ip_o,
   output logic             cs_chg_o,
   output logic             illegal_o,
   output logic             valid_o
);
   generate
      if (SHORT_W < 1 || SHORT_W >= IP_W) begin : g_bad_short
         $error("bta_unit: SHORT_W must lie in 1..IP_W-1");
      end
      if (SEG_W < 1 || IP_W < 2) begin : g_bad_width
         $error("bta_unit: widths too small");
      end
   endgenerate

   bk_ctl_t          ctl;
   logic [IP_W-1:0]  disp_ext;
   logic [SEG_W-1:0] nxt_cs;
   logic [IP_W-1:0]  nxt_ip;
   logic             nxt_chg;

   bta_decode u_dec (
      .kind_i (kind_i),
      .ctl_o  (ctl)
   );

   bta_disp_ext #(
      .IP_W     (IP_W),
      .SHORT_W  (SHORT_W),
      .SIGN_EXT (SIGN_EXT)
   ) u_ext (
      .disp_i      (disp_i),
      .use_short_i (ctl.use_short),
      .disp_o      (disp_ext)
   );

   bta_target_sel #(
      .IP_W  (IP_W),
      .SEG_W (SEG_W)
   ) u_sel (
      .ctl_i      (ctl),
      .cur_cs_i   (cur_cs_i),
      .cur_ip_i   (cur_ip_i),
      .disp_i     (disp_ext),
      .ptr_cs_i   (ptr_cs_i),
      .ptr_ip_i   (ptr_ip_i),
      .reg_word_i (reg_word_i),
      .mem_ip_i   (mem_ip_i),
      .mem_cs_i   (mem_cs_i),
      .cs_o       (nxt_cs),
      .ip_o       (nxt_ip),
      .chg_o      (nxt_chg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         new_cs_o  <= '0;
         new_ip_o  <= '0;
         cs_chg_o  <= 1'b0;
         illegal_o <= 1'b0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= req_i;
         if (req_i) begin
            new_cs_o  <= nxt_cs;
            new_ip_o  <= nxt_ip;
            cs_chg_o  <= nxt_chg;
            illegal_o <= ctl.bad;
         end
      end
   end
endmodule

// File: rtl/bta_unit_chk.sv
module bta_unit_chk #(
   parameter int IP_W  = 16,
   parameter int SEG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_i,
   input logic [2:0]       kind_i,
   input logic [SEG_W-1:0] cur_cs_i,
   input logic [IP_W-1:0]  cur_ip_i,
   input logic [SEG_W-1:0] ptr_cs_i,
   input logic [IP_W-1:0]  ptr_ip_i,
   input logic [SEG_W-1:0] mem_cs_i,
   input logic [IP_W-1:0]  mem_ip_i,
   input logic [SEG_W-1:0] new_cs_o,
   input logic [IP_W-1:0]  new_ip_o,
   input logic             cs_chg_o,
   input logic             illegal_o,
   input logic             valid_o
);
   a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> valid_o);
   a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !valid_o);
   a_r7_far_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && kind_i == 3'd4) |=> (new_cs_o == $past(ptr_cs_i) && new_ip_o == $past(ptr_ip_i)));
   a_r8_far_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && kind_i == 3'd5) |=> (new_cs_o == $past(mem_cs_i) && new_ip_o == $past(mem_ip_i)));
   a_r9_near_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !kind_i[2]) |=> (new_cs_o == $past(cur_cs_i) && !cs_chg_o));
   a_r10_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && illegal_o) |-> !cs_chg_o);
   a_r10_illegal_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && kind_i[2] && kind_i[1]) |=> (illegal_o && new_ip_o == $past(cur_ip_i)));
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> ($stable(new_cs_o) && $stable(new_ip_o) && $stable(cs_chg_o) && $stable(illegal_o)));
endmodule

bind bta_unit bta_unit_chk #(.IP_W(IP_W), .SEG_W(SEG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_i     (req_i),
   .kind_i    (kind_i),
   .cur_cs_i  (cur_cs_i),
   .cur_ip_i  (cur_ip_i),
   .ptr_cs_i  (ptr_cs_i),
   .ptr_ip_i  (ptr_ip_i),
   .mem_cs_i  (mem_cs_i),
   .mem_ip_i  (mem_ip_i),
   .new_cs_o  (new_cs_o),
   .new_ip_o  (new_ip_o),
   .cs_chg_o  (cs_chg_o),
   .illegal_o (illegal_o),
   .valid_o   (valid_o)
);

// File: tb/bta_unit_bench.sv
module bta_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [2:0]  kind_i = '0;
   logic [15:0] cur_cs_i = '0, cur_ip_i = '0, disp_i = '0;
   logic [15:0] ptr_cs_i = '0, ptr_ip_i = '0, reg_word_i = '0;
   logic [15:0] mem_ip_i = '0, mem_cs_i = '0;
   logic [15:0] new_cs_o, new_ip_o;
   logic        cs_chg_o, illegal_o, valid_o;

   int checks = 0;
   int failures = 0;
   int seed_v;

   always #(CLK_PERIOD/2) clk = ~clk;

   bta_unit u_bta_unit (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i),
      .cur_cs_i(cur_cs_i), .cur_ip_i(cur_ip_i), .disp_i(disp_i),
      .ptr_cs_i(ptr_cs_i), .ptr_ip_i(ptr_ip_i), .reg_word_i(reg_word_i),
      .mem_ip_i(mem_ip_i), .mem_cs_i(mem_cs_i),
      .new_cs_o(new_cs_o), .new_ip_o(new_ip_o), .cs_chg_o(cs_chg_o),
      .illegal_o(illegal_o), .valid_o(valid_o)
   );

   // expected {cs, ip, chg, ill}
   function automatic logic [33:0] expect_res(input logic [2:0] k);
      logic [15:0] cs, ip;
      logic chg, ill;
      cs = cur_cs_i; ip = cur_ip_i; chg = 1'b0; ill = 1'b0;
      case (k)
         3'd0: ip = cur_ip_i + {{8{disp_i[7]}}, disp_i[7:0]};
         3'd1: ip = cur_ip_i + disp_i;
         3'd2: ip = reg_word_i;
         3'd3: ip = mem_ip_i;
         3'd4: begin cs = ptr_cs_i; ip = ptr_ip_i; chg = 1'b1; end
         3'd5: begin cs = mem_cs_i; ip = mem_ip_i; chg = 1'b1; end
         default: ill = 1'b1;
      endcase
      return {cs, ip, chg, ill};
   endfunction

   function automatic string req_name(input logic [2:0] k);
      case (k)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string r, input logic [33:0] act, input logic [33:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // drive at negedge, result sampled at the following negedge
   task automatic run_one(input logic [2:0] k);
      logic [33:0] e;
      kind_i = k;
      req_i  = 1'b1;
      e = expect_res(k);
      @(negedge clk);
      req_i = 1'b0;
      check(req_name(k), {new_cs_o, new_ip_o, cs_chg_o, illegal_o}, e);
      check("R9", {33'd0, cs_chg_o}, {33'd0, e[1]});
      check("R2", {33'd0, valid_o}, 34'd1);
   endtask

   task automatic randomize_inputs();
      cur_cs_i   = 16'($urandom);
      cur_ip_i   = 16'($urandom);
      disp_i     = 16'($urandom);
      ptr_cs_i   = 16'($urandom);
      ptr_ip_i   = 16'($urandom);
      reg_word_i = 16'($urandom);
      mem_ip_i   = 16'($urandom);
      mem_cs_i   = 16'($urandom);
   endtask

   initial begin
      seed_v = $urandom(32'h5eed_b7a1);
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [33:0] held;
      repeat (3) @(negedge clk);
      check("R1", {new_cs_o, new_ip_o, cs_chg_o, illegal_o}, 34'd0);
      check("R1", {33'd0, valid_o}, 34'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {new_cs_o, new_ip_o, cs_chg_o, illegal_o}, 34'd0);

      // R3 negative short displacement with wrap below zero
      cur_cs_i = 16'h1234; cur_ip_i = 16'h0002; disp_i = 16'h00FC;
      run_one(3'd0);
      check("R3", {18'd0, new_ip_o}, {18'd0, 16'hFFFE});
      // R3 positive short, high byte of disp ignored
      cur_ip_i = 16'h1000; disp_i = 16'hAB7F;
      run_one(3'd0);
      check("R3", {18'd0, new_ip_o}, {18'd0, 16'h107F});
      // R4 long wrap above top
      cur_ip_i = 16'hFFF0; disp_i = 16'h0020;
      run_one(3'd1);
      check("R4", {18'd0, new_ip_o}, {18'd0, 16'h0010});
      // R7 and R8 far forms
      ptr_cs_i = 16'hF000; ptr_ip_i = 16'hFFF0;
      run_one(3'd4);
      mem_cs_i = 16'h0040; mem_ip_i = 16'h0123;
      run_one(3'd5);
      // R10 illegal immediate far indirect and unassigned code
      cur_cs_i = 16'hBEEF; cur_ip_i = 16'hCAFE;
      run_one(3'd6);
      run_one(3'd7);

      // R11 hold across idle cycles with changing inputs
      held = {new_cs_o, new_ip_o, cs_chg_o, illegal_o};
      for (int i = 0; i < 4; i++) begin
         randomize_inputs();
         kind_i = 3'(i);
         @(negedge clk);
         check("R11", {new_cs_o, new_ip_o, cs_chg_o, illegal_o}, held);
         check("R2", {33'd0, valid_o}, 34'd0);
      end

      // random mix, including back-to-back requests
      for (int n = 0; n < 400; n++) begin
         randomize_inputs();
         run_one(3'($urandom_range(0, 7)));
         if ($urandom_range(0, 2) == 0) begin
            held = {new_cs_o, new_ip_o, cs_chg_o, illegal_o};
            randomize_inputs();
            @(negedge clk);
            check("R11", {new_cs_o, new_ip_o, cs_chg_o, illegal_o}, held);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule